// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a 16-bit down-counting interval timer. It gives a steady time reference and raises a periodic interrupt flag. A free-running prescaler divides the system clock into a one-cycle timebase tick. With the default divide of 2500 at 250 MHz, that tick comes every 10 µs. While the timer is enabled, each tick moves an internal current count one step toward zero.

Software programs the reload value through a byte-wide write port. It writes the high byte first. That write only stages the byte. Writing the low byte commits the full 16-bit value into the current count at once.

When the count steps down to zero, the interrupt flag is raised. On the following tick the count is refilled from the reload value. Counting never stops for a pending flag, so the interval between flags stays fixed no matter how long software takes to service the interrupt. The flag is cleared by any write to the status address, or by writing a zero bit to the flag address.

Top module: `interval_timer`

## Requirements
- R1: After reset the current count, both reload bytes and the flag are all zero.
- R2: While `timerEn` is low, ticks leave the current count unchanged.
- R3: A write to address 0 stores the high reload byte and leaves the current count unchanged. A write to address 1 stores the low reload byte and, on the next cycle, sets the current count to {high byte, written byte}. This load takes priority over a tick in the same cycle.
- R4: While enabled, each tick at a non-zero count decrements the current count by one.
- R5: A tick that takes the count from 1 to 0 sets the flag.
- R6: A tick while the count is 0 reloads the count from {high byte, low byte}. A reload value N therefore gives one flag every N+1 ticks. A reload value of 0 keeps the count at 0 and never sets the flag.
- R7: Counting and reloading continue while the flag is set, and the flag stays set until it is cleared.
- R8: A write of any data to address 2 clears the flag.
- R9: A write to address 3 clears the flag when data bit 0 is 0. With bit 0 at 1 the write has no effect on the flag.
- R10: When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R11: `tick` is high for exactly one cycle out of every DIV cycles and runs whether or not the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerEn | input | 1 | Count enable |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write address: 0 high byte, 1 low byte, 2 status, 3 flag |
| wrData | input | BYTE_W | Write data |
| tick | output | 1 | Timebase tick from the prescaler |
| curCount | output | 2*BYTE_W | Current count |
| timerFlag | output | 1 | Timer interrupt flag |

## Verification
The count is stepped tick by tick from a small reload value. This separates decrement, zero detection and the reload on the tick after zero. It also shows that the flag survives the reload.

A disabled run and a high-byte-only write show that the count holds. A zero reload value shows that the timer stays at zero and never raises the flag.

The interval between flags is counted in ticks to confirm the fixed period of N+1. The flag is cleared in both ways, and a flag write with bit 0 set must leave it alone. One clearing write is placed in the exact cycle of a set event, where the flag must end up set.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [1:0] ADDR_HI     = 2'd0;
  localparam logic [1:0] ADDR_LO     = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic dec;
    logic reload;
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int DIV = 2500,
  parameter int CW  = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          timerEn,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic          wrBit0,
  input  logic [CW-1:0] count,
  output ivtStrobe_t    strobe,
  output logic          tick,
  output logic          flag
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PW'(DIV - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PW'(DIV - 1));

      assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  logic loWr, setEv, clrEv, run;

  always_comb begin
    loWr  = wrEn && (wrAddr == ADDR_LO);
    run   = tick && timerEn && !loWr;
    setEv = run && (count == ONE);
    clrEv = wrEn && ((wrAddr == ADDR_STATUS) || ((wrAddr == ADDR_FLAG) && !wrBit0));
    strobe.wrHi   = wrEn && (wrAddr == ADDR_HI);
    strobe.wrLo   = loWr;
    strobe.dec    = run && (count != '0);
    strobe.reload = run && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flag <= 1'b0;
    else if (setEv) flag <= 1'b1;
    else if (clrEv) flag <= 1'b0;
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && timerEn && !loWr && count == ONE) |=> flag);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (setEv && clrEv) |=> flag);
  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STATUS && !setEv) |=> !flag);
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ivtStrobe_t      strobe,
  input  logic [BW-1:0]   wrData,
  output logic [2*BW-1:0] count
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] baseHi, baseLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi <= '0;
      baseLo <= '0;
      count  <= '0;
    end else begin
      if (strobe.wrHi) baseHi <= wrData;
      if (strobe.wrLo) baseLo <= wrData;
      if (strobe.wrLo)        count <= {baseHi, wrData};
      else if (strobe.reload) count <= {baseHi, baseLo};
      else if (strobe.dec)    count <= count - CW'(1);
    end
  end

  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.wrLo) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV    = 2500
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                timerEn,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  output logic                tick,
  output logic [2*BYTE_W-1:0] curCount,
  output logic                timerFlag
);
  localparam int CW = 2 * BYTE_W;

  ivtStrobe_t strobe;

  ivt_ctrl #(.DIV(DIV), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBit0(wrData[0]), .count(curCount), .strobe(strobe), .tick(tick),
    .flag(timerFlag)
  );

  ivt_datapath #(.BW(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .count(curCount)
  );

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !(wrEn && wrAddr == ADDR_LO)) |=> $stable(curCount));
  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_LO) |=> (curCount[BYTE_W-1:0] == $past(wrData)));
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic        tick;
  logic [15:0] curCount;
  logic        timerFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  interval_timer #(.BYTE_W(8), .DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tick(tick), .curCount(curCount), .timerFlag(timerFlag)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTick();
    while (tick !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 count", curCount, 0);
    chk("R1 flag", timerFlag, 0);
  endtask

  task automatic testLoad();
    wr(2'd0, 8'h12);
    chk("R3 high write keeps count", curCount, 0);
    wr(2'd1, 8'h03);
    chk("R3 low write loads", curCount, 16'h1203);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03);
    chk("R3 reload 3", curCount, 3);
  endtask

  task automatic testDisabled();
    repeat (3) waitTick();
    chk("R2 disabled hold", curCount, 3);
  endtask

  task automatic testCount();
    timerEn = 1'b1;
    waitTick(); chk("R4 dec 3->2", curCount, 2);
    waitTick(); chk("R4 dec 2->1", curCount, 1);
    chk("R5 no flag yet", timerFlag, 0);
    waitTick(); chk("R5 count 0", curCount, 0);
    chk("R5 flag set", timerFlag, 1);
    waitTick(); chk("R6 reload", curCount, 3);
    chk("R7 flag held", timerFlag, 1);
    waitTick(); chk("R7 counts on", curCount, 2);
  endtask

  task automatic testClear();
    wr(2'd2, 8'hA5);
    chk("R8 status clear", timerFlag, 0);
    while (timerFlag !== 1'b1) waitTick();
    wr(2'd3, 8'h01);
    chk("R9 bit0=1 no effect", timerFlag, 1);
    wr(2'd3, 8'hFE);
    chk("R9 bit0=0 clears", timerFlag, 0);
  endtask

  task automatic testPeriod();
    int n;
    while (timerFlag !== 1'b1) waitTick();
    wr(2'd2, 8'h00);
    n = 0;
    while (timerFlag !== 1'b1) begin waitTick(); n++; end
    chk("R6 period ticks", n, 4);
  endtask

  task automatic testPrescale();
    int c;
    while (tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    c = 1;
    while (tick !== 1'b1) begin @(negedge clk); c++; end
    chk("R11 tick spacing", c, DIV);
  endtask

  task automatic testSetWins();
    wr(2'd2, 8'h00);
    while (!(tick === 1'b1 && curCount == 16'd1)) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10 set wins", timerFlag, 1);
    chk("R10 count 0", curCount, 0);
  endtask

  task automatic testZeroBase();
    timerEn = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    timerEn = 1'b1;
    repeat (3) waitTick();
    chk("R6 zero base count", curCount, 0);
    chk("R6 zero base no flag", timerFlag, 0);
    timerEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testDisabled();
    testCount();
    testClear();
    testPeriod();
    testPrescale();
    testSetWins();
    testZeroBase();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule